// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block models, on a system clock, the control logic of a byte-wide parallel EEPROM. It samples the active-low chip-enable, output-enable and write-enable pins on each clock, decodes them into read and write cycles, and captures the address and data at the strobe edges. Bytes written in quick succession are collected in a page buffer. When the host stops loading for long enough, a self-timed program cycle copies every loaded byte into a behavioural storage array.

While the program cycle runs, reads do not return array contents. They return a status byte. Bit 7 carries the inverse of bit 7 of the last byte loaded (data polling). Bit 6 flips after each completed read (toggle). Software detects the end of the write when bit 7 matches the written data again or when bit 6 stops changing. The program time and the page-load timeout are counted in clock ticks and set by parameters.

Top module: `pe_page_ctrl`

## Requirements
- R1: The array holds 2**ADDR_W bytes (ADDR_W=16 gives 64K), and every byte reads as 0xFF after reset.
- R2: `dout_en` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. Outside a program cycle, `dout` then shows the stored byte at `addr`.
- R3: A write cycle exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1. Driving `ce_n` and `we_n` low with `oe_n` low loads nothing.
- R4: The address is taken on the first clock that samples the write condition true, which is the later of the two falling strobes. Address changes after that clock are ignored.
- R5: The data is the value of `din` on the last clock that samples the write condition true, which is the earlier of the two rising strobes. A `din` change that arrives together with the rising strobe is ignored.
- R6: Bits [PAGE_W-1:0] of the address select the byte within the page, and the upper bits select the page. The page is taken from the most recent load. One program cycle commits from 1 to 2**PAGE_W bytes (128 by default).
- R7: A program cycle starts once T_LOAD consecutive clocks pass with no write cycle active since the last load. Each new load restarts this count.
- R8: A program cycle lasts T_WRITE clocks. After it, reads return the newly written bytes.
- R9: During a program cycle, a read returns bit 7 as the inverse of bit 7 of the last loaded byte and bits 5:0 as that byte's bits 5:0. After the cycle, reads return true data.
- R10: During a program cycle, bit 6 of the read data inverts after each completed read, so two consecutive reads differ in bit 6. Outside a program cycle, the toggle state does not change.
- R11: Write cycles made during a program cycle are ignored and change no byte of the array.
- R12: The page buffer is emptied when a program cycle ends. A later program cycle writes only the bytes loaded for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data or program-cycle status |
| dout_en | output | 1 | Drive enable for the data bus (0 means high impedance) |

## Verification
The bound checker checks on every cycle the following invariants:
- The bus is released whenever `ce_n` or `oe_n` is high.
- The polling bit is inverted for every read made during programming.
- The toggle state holds still outside programming.
- The page buffer does not change while the program cycle runs.
- The page buffer is empty when programming ends.

Only the bench's scenarios can show the rest:
- Which address and data edge a write actually captures, under both WE-controlled and CE-controlled strobes.
- That the load timer restarts on each byte.
- That the program cycle lasts long enough.
- That stale page contents never reach a later page.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
   typedef logic [7:0] pe_byte_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOAD = 2'd1,
      ST_PROG = 2'd2
   } pe_state_e;

   localparam pe_byte_t ERASED = 8'hFF;
endpackage

// File: rtl/pe_strobe_decode.sv
`timescale 1ns/1ps
module pe_strobe_decode #(
   parameter int ADDR_W = 11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce_n,
   input  logic                 oe_n,
   input  logic                 we_n,
   input  logic [ADDR_W-1:0]    addr,
   input  pe_pkg::pe_byte_t     din,
   output logic                 wr_act,
   output logic                 ld_done,
   output logic [ADDR_W-1:0]    ld_addr,
   output pe_pkg::pe_byte_t     ld_data,
   output logic                 rd_done
);
   logic             wr_q, rd_q, rd_now;
   pe_pkg::pe_byte_t din_q;

   assign wr_act = !ce_n && !we_n && oe_n;
   assign rd_now = !ce_n && !oe_n && we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         rd_q    <= 1'b0;
         din_q   <= '0;
         ld_addr <= '0;
      end else begin
         wr_q  <= wr_act;
         rd_q  <= rd_now;
         din_q <= din;
         // Later falling strobe: first sample with the write condition true
         if (wr_act && !wr_q)
            ld_addr <= addr;
      end
   end

   // Earlier rising strobe: data is the last value seen while still low
   assign ld_done = wr_q && !wr_act;
   assign ld_data = din_q;
   assign rd_done = rd_q && !rd_now;
endmodule

// File: rtl/pe_page_buffer.sv
`timescale 1ns/1ps
module pe_page_buffer #(
   parameter int ADDR_W = 11,
   parameter int PAGE_W = 7,
   localparam int PAGE_BYTES = 1 << PAGE_W,
   localparam int PG_W = ADDR_W - PAGE_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic [ADDR_W-1:0]     ld_addr,
   input  pe_pkg::pe_byte_t      ld_data,
   input  logic                  clear,
   input  logic [PAGE_W-1:0]     rd_idx,
   output pe_pkg::pe_byte_t      rd_byte,
   output logic                  rd_valid,
   output logic [PAGE_BYTES-1:0] valid,
   output logic [PG_W-1:0]       page,
   output pe_pkg::pe_byte_t      last_byte
);
   pe_pkg::pe_byte_t slots [PAGE_BYTES];
   logic [PAGE_W-1:0] off;

   assign off = ld_addr[PAGE_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid     <= '0;
         page      <= '0;
         last_byte <= '0;
      end else if (clear) begin
         valid <= '0;
      end else if (load) begin
         valid[off] <= 1'b1;
         page       <= ld_addr[ADDR_W-1:PAGE_W];
         last_byte  <= ld_data;
      end
   end

   always_ff @(posedge clk) begin
      if (load && !clear)
         slots[off] <= ld_data;
   end

   assign rd_byte  = slots[rd_idx];
   assign rd_valid = valid[rd_idx];
endmodule

// File: rtl/pe_sequencer.sv
`timescale 1ns/1ps
module pe_sequencer #(
   parameter int PAGE_W  = 7,
   parameter int T_LOAD  = 30,
   parameter int T_WRITE = 1000,
   localparam int T_MAX  = (T_LOAD > T_WRITE) ? T_LOAD : T_WRITE,
   localparam int CW     = $clog2(T_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              wr_act,
   input  logic              rd_done,
   output logic              busy,
   output logic              loading,
   output logic              commit_en,
   output logic [PAGE_W-1:0] commit_idx,
   output logic              clear,
   output logic              tog
);
   import pe_pkg::*;
   pe_state_e      st;
   logic [CW-1:0]  cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         cnt <= '0;
         tog <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               cnt <= '0;
               if (load) st <= ST_LOAD;
            end
            ST_LOAD: begin
               if (load || wr_act)
                  cnt <= '0;
               else if (cnt == CW'(T_LOAD - 1)) begin
                  st  <= ST_PROG;
                  cnt <= '0;
               end else
                  cnt <= cnt + 1'b1;
            end
            ST_PROG: begin
               if (cnt == CW'(T_WRITE - 1)) begin
                  st  <= ST_IDLE;
                  cnt <= '0;
               end else
                  cnt <= cnt + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
         if (st == ST_PROG && rd_done)
            tog <= ~tog;
      end
   end

   assign busy       = (st == ST_PROG);
   assign loading    = (st == ST_LOAD);
   assign commit_en  = busy && (cnt < CW'(1 << PAGE_W));
   assign commit_idx = cnt[PAGE_W-1:0];
   assign clear      = busy && (cnt == CW'(T_WRITE - 1));
endmodule

// File: rtl/pe_page_ctrl.sv
`timescale 1ns/1ps
module pe_page_ctrl #(
   parameter int ADDR_W  = 11,
   parameter int PAGE_W  = 7,
   parameter int T_LOAD  = 30,
   parameter int T_WRITE = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dout,
   output logic              dout_en
);
   import pe_pkg::*;
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int PAGE_BYTES = 1 << PAGE_W;
   localparam int PG_W       = ADDR_W - PAGE_W;

   generate
      if (PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_page
         $error("PAGE_W must lie between 1 and ADDR_W-1");
      end
      if (T_WRITE < PAGE_BYTES) begin : g_bad_write
         $error("T_WRITE must cover one clock per page byte");
      end
      if (T_LOAD < 2) begin : g_bad_load
         $error("T_LOAD must be at least 2 clocks");
      end
   endgenerate

   logic               wr_act, ld_done, rd_done, load;
   logic [ADDR_W-1:0]  ld_addr;
   pe_byte_t           ld_data, cm_byte, last_byte;
   logic               cm_valid, busy, loading, commit_en, clear, tog;
   logic [PAGE_W-1:0]  commit_idx;
   logic [PAGE_BYTES-1:0] pg_valid;
   logic [PG_W-1:0]    page;
   pe_byte_t           mem [DEPTH];

   pe_strobe_decode #(.ADDR_W(ADDR_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .wr_act(wr_act), .ld_done(ld_done),
      .ld_addr(ld_addr), .ld_data(ld_data), .rd_done(rd_done)
   );

   assign load = ld_done && !busy;

   pe_page_buffer #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(ld_addr),
      .ld_data(ld_data), .clear(clear), .rd_idx(commit_idx),
      .rd_byte(cm_byte), .rd_valid(cm_valid), .valid(pg_valid),
      .page(page), .last_byte(last_byte)
   );

   pe_sequencer #(.PAGE_W(PAGE_W), .T_LOAD(T_LOAD), .T_WRITE(T_WRITE)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(load), .wr_act(wr_act),
      .rd_done(rd_done), .busy(busy), .loading(loading),
      .commit_en(commit_en), .commit_idx(commit_idx), .clear(clear),
      .tog(tog)
   );

   // Behavioural array: one page byte committed per clock early in the cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
      end else if (commit_en && cm_valid) begin
         mem[{page, commit_idx}] <= cm_byte;
      end
   end

   assign dout_en = !ce_n && !oe_n && we_n;
   assign dout    = busy ? {~last_byte[7], tog, last_byte[5:0]} : mem[addr];
endmodule

// File: rtl/pe_page_ctrl_chk.sv
`timescale 1ns/1ps
module pe_page_ctrl_chk #(
   parameter int PAGE_BYTES = 128
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  ce_n,
   input logic                  oe_n,
   input logic                  dout_en,
   input logic [7:0]            dout,
   input logic                  busy,
   input logic                  loading,
   input logic [7:0]            last_byte,
   input logic                  tog,
   input logic [PAGE_BYTES-1:0] valid
);
   a_r2_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_n || oe_n) |-> !dout_en);

   a_r9_poll_inv: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dout_en) |-> (dout[7] == ~last_byte[7]));

   a_r10_tog_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(tog));

   a_r11_buf_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(valid)));

   a_r12_buf_empty: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (valid == '0));

   a_r6_page_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      loading |-> (valid != '0));
endmodule

bind pe_page_ctrl pe_page_ctrl_chk #(.PAGE_BYTES(PAGE_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .dout_en(dout_en),
   .dout(dout), .busy(busy), .loading(loading), .last_byte(last_byte),
   .tog(tog), .valid(pg_valid)
);

// File: tb/pe_page_ctrl_test.sv
`timescale 1ns/1ps
module pe_page_ctrl_test;
   localparam int AW = 11;
   localparam int TL = 20;
   localparam int TW = 200;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [7:0]    din = '0;
   logic [7:0]    dout;
   logic          dout_en;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic smp = 1'b0;

   typedef struct {
      logic [7:0] exp;
      logic [7:0] mask;
      string      tag;
   } item_t;
   item_t sb[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pe_page_ctrl #(.ADDR_W(AW), .PAGE_W(7), .T_LOAD(TL), .T_WRITE(TW)) uut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Monitor: compares queued expectations away from the clock edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (smp) begin
            item_t it;
            if (sb.size() == 0) chk(0, "scoreboard empty", 0, 1);
            else begin
               it = sb.pop_front();
               chk(((dout & it.mask) == (it.exp & it.mask)) && dout_en,
                   it.tag, dout & it.mask, it.exp & it.mask);
            end
         end
      end
   end

   task automatic rd_exp(input logic [AW-1:0] a, input logic [7:0] e,
                         input logic [7:0] m, input string tag);
      item_t it;
      it.exp = e; it.mask = m; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      addr = a; ce_n = 0; oe_n = 0; we_n = 1; smp = 1;
      @(negedge clk);
      smp = 0; oe_n = 1; ce_n = 1;
   endtask

   task automatic rd_raw(input logic [AW-1:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a; ce_n = 0; oe_n = 0; we_n = 1;
      @(posedge clk);
      #2 v = dout;
      @(negedge clk);
      oe_n = 1; ce_n = 1;
   endtask

   task automatic wr_we(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; din = d; ce_n = 0;
      @(negedge clk); we_n = 0;
      repeat (2) @(negedge clk);
      we_n = 1;
      @(negedge clk); ce_n = 1;
      @(negedge clk);
   endtask

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic wait_prog(input logic [AW-1:0] a, input logic [7:0] d);
      logic [7:0] v;
      bit done = 0;
      for (int k = 0; k < 400 && !done; k++) begin
         rd_raw(a, v);
         if (v[7] == d[7]) done = 1;
      end
      chk(done, "R8 program cycle never ended", 0, 1);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      int t0;
      logic [7:0] v1, v2;
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      #1 chk(dout_en == 0, "R2 bus released after reset", dout_en, 0);
      rd_exp(11'h005, 8'hFF, 8'hFF, "R1 erased after reset");
      rd_exp(11'h7FF, 8'hFF, 8'hFF, "R1 erased top byte");

      // R3: oe_n low during ce_n/we_n low is no write; bus stays off (R2)
      @(negedge clk);
      addr = 11'h010; din = 8'h12; ce_n = 0; oe_n = 0; we_n = 0;
      @(posedge clk);
      #2 chk(dout_en == 0, "R2 no drive with we_n low", dout_en, 0);
      repeat (3) @(negedge clk);
      we_n = 1; oe_n = 1; ce_n = 1;
      repeat (TL + TW + 10) @(negedge clk);
      rd_exp(11'h010, 8'hFF, 8'hFF, "R3 write with oe_n low ignored");

      // Page at 0x080, four bytes; last byte 0xC4
      wr_we(11'h080, 8'h11);
      wr_we(11'h081, 8'h22);
      wr_we(11'h082, 8'h33);
      wr_we(11'h083, 8'hC4);
      t0 = cyc;
      wait_until(t0 + TL + 5);
      rd_exp(11'h081, 8'h04, 8'hBF, "R9 polling bit7 inverted, low bits of last byte");
      rd_raw(11'h081, v1);
      rd_raw(11'h081, v2);
      chk(v1[6] != v2[6], "R10 toggle between reads", v2[6], ~v1[6]);
      wr_we(11'h0A0, 8'h55);
      wr_we(11'h300, 8'h66);
      wait_until(t0 + TL + TW - 10);
      rd_exp(11'h080, 8'h00, 8'h80, "R7 R8 still programming near end");
      wait_until(t0 + TL + TW + 12);
      rd_exp(11'h080, 8'h11, 8'hFF, "R8 byte0 committed");
      rd_exp(11'h081, 8'h22, 8'hFF, "R8 byte1 committed");
      rd_exp(11'h082, 8'h33, 8'hFF, "R8 byte2 committed");
      rd_exp(11'h083, 8'hC4, 8'hFF, "R9 true data after cycle");
      rd_exp(11'h0A0, 8'hFF, 8'hFF, "R11 write during program ignored (same page)");
      rd_exp(11'h300, 8'hFF, 8'hFF, "R11 write during program ignored (other page)");
      rd_raw(11'h083, v1);
      rd_raw(11'h083, v2);
      chk(v1 == v2, "R10 no toggle when idle", v2, v1);

      // CE-controlled write: address on later fall (ce_n), data on earlier rise (ce_n)
      @(negedge clk); addr = 11'h1FF; din = 8'h6B; we_n = 0;
      @(negedge clk); ce_n = 0; addr = 11'h105;
      @(negedge clk); addr = 11'h1FE;
      @(negedge clk); ce_n = 1; din = 8'h94;
      @(negedge clk); we_n = 1;
      @(negedge clk);
      t0 = cyc;
      wait_until(t0 + TL + 5);
      rd_exp(11'h105, 8'h80, 8'h80, "R9 polling for bit7=0 byte");
      wait_prog(11'h105, 8'h6B);
      rd_exp(11'h105, 8'h6B, 8'hFF, "R4 R5 CE-controlled capture");
      rd_exp(11'h1FF, 8'hFF, 8'hFF, "R4 early address not used");
      rd_exp(11'h1FE, 8'hFF, 8'hFF, "R4 late address not used");
      rd_exp(11'h100, 8'hFF, 8'hFF, "R12 stale slot 0 not rewritten");
      rd_exp(11'h103, 8'hFF, 8'hFF, "R12 stale slot 3 not rewritten");

      // R7: gaps below T_LOAD keep the page open
      wr_we(11'h180, 8'h80);
      repeat (TL - 6) @(negedge clk);
      wr_we(11'h181, 8'h81);
      repeat (TL - 6) @(negedge clk);
      rd_exp(11'h190, 8'hFF, 8'hFF, "R7 timer restarted, not yet programming");
      wr_we(11'h182, 8'h02);
      wait_prog(11'h182, 8'h02);
      rd_exp(11'h180, 8'h80, 8'hFF, "R7 first byte of spaced loads");
      rd_exp(11'h181, 8'h81, 8'hFF, "R7 second byte of spaced loads");
      rd_exp(11'h182, 8'h02, 8'hFF, "R7 third byte of spaced loads");

      // R6: full 128-byte page
      for (int i = 0; i < 128; i++) wr_we(AW'(11'h200 + i), 8'(i * 3 + 1));
      wait_prog(11'h27F, 8'(127 * 3 + 1));
      for (int i = 0; i < 128; i++)
         rd_exp(AW'(11'h200 + i), 8'(i * 3 + 1), 8'hFF, "R6 full page byte");
      rd_exp(11'h280, 8'hFF, 8'hFF, "R6 next page untouched");

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "scoreboard drained", sb.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule